// File: doc/BRIEF.md
# Timed Event Command Scheduler

This block keeps a small associative store of pending commands. Each command names a 16-bit target time, one of two free-running 16-bit timers as its reference, an action, and whether an interrupt should go with it. A periodic compare tick checks every pending command against its chosen timer. Each command that matches performs its action and then leaves the store, so its slot can be reused.

The actions are: drive chosen output lines high, drive chosen output lines low, pulse a converter-start request, pulse a request to reset the second timer, and pulse one of four software delay flags. The timers and the converter are outside the block. Timer values come in as inputs, and the requests go out as single-cycle pulses.

Commands enter through a load port. A command is taken whenever a slot is free. When all slots are occupied, the load is refused and a full flag is shown.

Top module: `tes_sched`

## Requirements
- R1: When `full` is low, a load (`ld_valid` high) is accepted: `ld_accept` is high in that cycle and the command is stored in a free slot. The store holds at most 8 commands.
- R2: `full` is high exactly when all 8 slots hold a command. While `full` is high, `ld_accept` is low and the offered command has no effect; in particular it never fires.
- R3: Comparison happens only on a compare tick, which recurs every 8 clock cycles. All action outputs change only in the cycle after a tick, so any two action events are a multiple of 8 cycles apart.
- R4: A command matches only when its stored time is exactly equal to its selected timer. Select 0 compares against `timer1` and select 1 compares against `timer2`.
- R5: A command that fires is removed from the store in that same tick and never fires again.
- R6: Every command that matches on a given tick fires on that tick, and the effects of all of them are combined into one output update.
- R7: Action code 0 sets the `out_lines` bits given by the 6-bit argument mask. Action code 1 clears the bits given by the mask. When the same bit is both set and cleared on one tick, set wins. `out_lines` is held between ticks.
- R8: Action code 2 pulses `adc_start` for one cycle. Code 3 pulses `t2_reset` for one cycle. Code 4 pulses `swt_event[arg[1:0]]` for one cycle. Codes 5 to 7 perform no action.
- R9: `irq` pulses for one cycle after any tick on which at least one firing command has its interrupt bit set.
- R10: After synchronous reset the store is empty, `full` is low, `out_lines` is 0 and every pulse output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Offer a command for loading |
| ld_time | input | 16 | Target time of the offered command |
| ld_kind | input | 3 | Action code (0 set, 1 clear, 2 converter start, 3 timer-2 reset, 4 software flag) |
| ld_arg | input | 6 | Line mask for codes 0 and 1; flag index in bits 1:0 for code 4 |
| ld_irq_en | input | 1 | Request an interrupt when the command fires |
| ld_tsel | input | 1 | Reference timer select (0 = timer1, 1 = timer2) |
| ld_accept | output | 1 | Offered command is being stored this cycle |
| full | output | 1 | All slots occupied |
| timer1 | input | 16 | First reference timer value |
| timer2 | input | 16 | Second reference timer value |
| out_lines | output | 6 | Registered output lines |
| adc_start | output | 1 | Converter-start pulse |
| t2_reset | output | 1 | Timer-2 reset pulse |
| swt_event | output | 4 | Software delay flag pulses |
| irq | output | 1 | Interrupt pulse |

## Verification
The assertions assume that `ld_valid` and the load fields are clean, known values in every cycle after reset. They also assume that the timer inputs never carry X, because a match is an exact equality test on them. The stimulus drives every load field and both timers at the falling edge, and it keeps the timers at a value that no stored command targets, except during deliberate match windows. Each match window lasts longer than two compare periods, so every expected firing falls inside one window. The same windows show that a command fires only once, since a second tick occurs while the timer still matches.

// File: rtl/tes_pkg.sv
package tes_pkg;
  localparam int TW    = 16;
  localparam int NLINE = 6;
  localparam int NSWT  = 4;
  localparam int SWTW  = $clog2(NSWT);
  localparam int ARGW  = NLINE;

  typedef enum logic [2:0] {
    ACT_SET   = 3'd0,
    ACT_CLR   = 3'd1,
    ACT_ADC   = 3'd2,
    ACT_T2RST = 3'd3,
    ACT_SWT   = 3'd4,
    ACT_NOP5  = 3'd5,
    ACT_NOP6  = 3'd6,
    ACT_NOP7  = 3'd7
  } act_e;

  typedef struct packed {
    logic [TW-1:0]   when;
    act_e            kind;
    logic [ARGW-1:0] arg;
    logic            irq_en;
    logic            tsel;
  } cmd_t;
endpackage

// File: rtl/tes_tick.sv
module tes_tick #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/tes_slot.sv
module tes_slot
  import tes_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  cmd_t          wr_cmd,
  input  logic          tick,
  input  logic [TW-1:0] timer1,
  input  logic [TW-1:0] timer2,
  output logic          valid,
  output cmd_t          cmd,
  output logic          fire
);
  logic [TW-1:0] ref_time;

  // Payload has no reset; only the valid bit gates its use.
  always_ff @(posedge clk) begin
    if (wr_en) cmd <= wr_cmd;
  end

  always_ff @(posedge clk) begin
    if (rst)        valid <= 1'b0;
    else if (wr_en) valid <= 1'b1;
    else if (fire)  valid <= 1'b0;
  end

  assign ref_time = cmd.tsel ? timer2 : timer1;
  assign fire     = valid & tick & (cmd.when == ref_time);
endmodule

// File: rtl/tes_alloc.sv
module tes_alloc #(
  parameter int SLOTS = 8
) (
  input  logic [SLOTS-1:0] valid,
  input  logic             req,
  output logic [SLOTS-1:0] grant,
  output logic             full
);
  logic found;

  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (!valid[i] && !found) begin
        grant[i] = req;
        found    = 1'b1;
      end
    end
  end

  assign full = &valid;
endmodule

// File: rtl/tes_action.sv
module tes_action
  import tes_pkg::*;
#(
  parameter int SLOTS = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [SLOTS-1:0]      fire,
  input  cmd_t [SLOTS-1:0]      cmds,
  output logic [NLINE-1:0]      out_lines,
  output logic                  adc_start,
  output logic                  t2_reset,
  output logic [NSWT-1:0]       swt_event,
  output logic                  irq
);
  logic [NLINE-1:0] set_m, clr_m;
  logic             adc_n, t2_n, irq_n;
  logic [NSWT-1:0]  swt_n;

  always_comb begin
    set_m = '0;
    clr_m = '0;
    adc_n = 1'b0;
    t2_n  = 1'b0;
    swt_n = '0;
    irq_n = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (fire[i]) begin
        case (cmds[i].kind)
          ACT_SET:   set_m = set_m | cmds[i].arg[NLINE-1:0];
          ACT_CLR:   clr_m = clr_m | cmds[i].arg[NLINE-1:0];
          ACT_ADC:   adc_n = 1'b1;
          ACT_T2RST: t2_n  = 1'b1;
          ACT_SWT:   swt_n[cmds[i].arg[SWTW-1:0]] = 1'b1;
          default:   ;
        endcase
        if (cmds[i].irq_en) irq_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_lines <= '0;
      adc_start <= 1'b0;
      t2_reset  <= 1'b0;
      swt_event <= '0;
      irq       <= 1'b0;
    end else begin
      out_lines <= (out_lines & ~clr_m) | set_m;
      adc_start <= adc_n;
      t2_reset  <= t2_n;
      swt_event <= swt_n;
      irq       <= irq_n;
    end
  end
endmodule

// File: rtl/tes_sched.sv
module tes_sched
  import tes_pkg::*;
#(
  parameter int SLOTS    = 8,
  parameter int TICK_DIV = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ld_valid,
  input  logic [15:0]          ld_time,
  input  logic [2:0]           ld_kind,
  input  logic [5:0]           ld_arg,
  input  logic                 ld_irq_en,
  input  logic                 ld_tsel,
  output logic                 ld_accept,
  output logic                 full,
  input  logic [15:0]          timer1,
  input  logic [15:0]          timer2,
  output logic [5:0]           out_lines,
  output logic                 adc_start,
  output logic                 t2_reset,
  output logic [3:0]           swt_event,
  output logic                 irq
);
  logic             tick;
  logic [SLOTS-1:0] valid;
  logic [SLOTS-1:0] fire;
  logic [SLOTS-1:0] grant;
  cmd_t [SLOTS-1:0] cmds;
  cmd_t             new_cmd;

  assign new_cmd.when   = ld_time;
  assign new_cmd.kind   = act_e'(ld_kind);
  assign new_cmd.arg    = ld_arg;
  assign new_cmd.irq_en = ld_irq_en;
  assign new_cmd.tsel   = ld_tsel;

  tes_tick #(.DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  tes_alloc #(.SLOTS(SLOTS)) u_alloc (
    .valid (valid),
    .req   (ld_valid),
    .grant (grant),
    .full  (full)
  );

  assign ld_accept = ld_valid & ~full;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    tes_slot u_slot (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (grant[g]),
      .wr_cmd (new_cmd),
      .tick   (tick),
      .timer1 (timer1),
      .timer2 (timer2),
      .valid  (valid[g]),
      .cmd    (cmds[g]),
      .fire   (fire[g])
    );
  end

  tes_action #(.SLOTS(SLOTS)) u_action (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .cmds      (cmds),
    .out_lines (out_lines),
    .adc_start (adc_start),
    .t2_reset  (t2_reset),
    .swt_event (swt_event),
    .irq       (irq)
  );
endmodule

// File: rtl/tes_sched_chk.sv
module tes_sched_chk #(
  parameter int SLOTS = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             ld_valid,
  input logic             ld_accept,
  input logic             full,
  input logic             tick,
  input logic [SLOTS-1:0] fire,
  input logic [SLOTS-1:0] valid,
  input logic [5:0]       out_lines,
  input logic             adc_start,
  input logic             t2_reset,
  input logic [3:0]       swt_event,
  input logic             irq
);
  assert_load_taken_R1: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && !full) |-> ld_accept);

  assert_full_refuse_R2: assert property (@(posedge clk) disable iff (rst)
    full |-> !ld_accept);

  assert_pulse_after_tick_R3: assert property (@(posedge clk) disable iff (rst)
    (adc_start || t2_reset || irq || (swt_event != 4'd0)) |-> $past(tick));

  assert_lines_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(tick) |-> $stable(out_lines));

  assert_fired_cleared_R5: assert property (@(posedge clk) disable iff (rst)
    (fire != '0) |=> ((valid & $past(fire)) == '0));

  assert_adc_single_R8: assert property (@(posedge clk) disable iff (rst)
    adc_start |=> !adc_start);

  assert_irq_single_R9: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
endmodule

bind tes_sched tes_sched_chk #(.SLOTS(SLOTS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ld_valid  (ld_valid),
  .ld_accept (ld_accept),
  .full      (full),
  .tick      (tick),
  .fire      (fire),
  .valid     (valid),
  .out_lines (out_lines),
  .adc_start (adc_start),
  .t2_reset  (t2_reset),
  .swt_event (swt_event),
  .irq       (irq)
);

// File: tb/tes_sched_test.sv
`timescale 1ns/1ps
module tes_sched_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_valid = 1'b0;
  logic [15:0] ld_time = '0;
  logic [2:0]  ld_kind = '0;
  logic [5:0]  ld_arg = '0;
  logic        ld_irq_en = 1'b0;
  logic        ld_tsel = 1'b0;
  logic        ld_accept, full;
  logic [15:0] timer1 = '0, timer2 = '0;
  logic [5:0]  out_lines;
  logic        adc_start, t2_reset, irq;
  logic [3:0]  swt_event;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int first_ev = -1;
  logic [5:0] prev_lines = '0;
  bit mon_on = 1'b0;

  typedef struct {
    logic [5:0] lines;
    logic       adc;
    logic       t2;
    logic [3:0] swt;
    logic       irq;
    string      tag;
  } ev_t;
  ev_t exp_q[$];

  always #2.5 clk = ~clk;

  tes_sched uut (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_time(ld_time),
    .ld_kind(ld_kind), .ld_arg(ld_arg), .ld_irq_en(ld_irq_en),
    .ld_tsel(ld_tsel), .ld_accept(ld_accept), .full(full),
    .timer1(timer1), .timer2(timer2), .out_lines(out_lines),
    .adc_start(adc_start), .t2_reset(t2_reset), .swt_event(swt_event),
    .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) cyc++;

  // Monitor: pops one expected item for each observed action event.
  always @(negedge clk) begin
    if (mon_on) begin
      if (adc_start || t2_reset || irq || swt_event != 4'd0 || out_lines != prev_lines) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5", "unexpected event lines", int'(out_lines), int'(prev_lines));
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          check(out_lines == e.lines, e.tag, "out_lines", int'(out_lines), int'(e.lines));
          check(adc_start == e.adc, e.tag, "adc_start", int'(adc_start), int'(e.adc));
          check(t2_reset == e.t2, e.tag, "t2_reset", int'(t2_reset), int'(e.t2));
          check(swt_event == e.swt, e.tag, "swt_event", int'(swt_event), int'(e.swt));
          check(irq == e.irq, e.tag, "irq", int'(irq), int'(e.irq));
        end
        if (first_ev < 0) first_ev = cyc;
        else check(((cyc - first_ev) % 8) == 0, "R3", "event spacing mod 8",
                   (cyc - first_ev) % 8, 0);
      end
      prev_lines = out_lines;
    end
  end

  task automatic load(input logic [15:0] t, input logic [2:0] k, input logic [5:0] a,
                      input logic ie, input logic ts, input logic exp_acc, input string tag);
    @(negedge clk);
    ld_valid = 1'b1; ld_time = t; ld_kind = k; ld_arg = a; ld_irq_en = ie; ld_tsel = ts;
    #1;
    check(ld_accept == exp_acc, tag, "ld_accept", int'(ld_accept), int'(exp_acc));
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic push(input logic [5:0] l, input logic ad, input logic t2,
                      input logic [3:0] sw, input logic iq, input string tag);
    ev_t e;
    e.lines = l; e.adc = ad; e.t2 = t2; e.swt = sw; e.irq = iq; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Holds the timers for 20 cycles (at least two ticks), then idles them.
  task automatic window(input logic [15:0] t1v, input logic [15:0] t2v, input string tag);
    @(negedge clk);
    timer1 = t1v; timer2 = t2v;
    repeat (20) @(negedge clk);
    timer1 = 16'h0000; timer2 = 16'h0000;
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, tag, "pending expected events", exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_lines == 6'd0, "R10", "out_lines", int'(out_lines), 0);
    check(full == 1'b0, "R10", "full", int'(full), 0);
    check({adc_start, t2_reset, irq, swt_event} == 7'd0, "R10", "pulses",
          int'({adc_start, t2_reset, irq, swt_event}), 0);
    prev_lines = out_lines;
    mon_on = 1'b1;

    // R7 / R9: set lines 0 and 2 on timer1, with interrupt; fires once (R5)
    load(16'h1234, 3'd0, 6'b000101, 1'b1, 1'b0, 1'b1, "R1");
    push(6'b000101, 1'b0, 1'b0, 4'd0, 1'b1, "R7");
    window(16'h1234, 16'h0000, "R5");

    // R4: clear line 0 referenced to timer2, no interrupt
    load(16'h0042, 3'd1, 6'b000001, 1'b0, 1'b1, 1'b1, "R1");
    push(6'b000100, 1'b0, 1'b0, 4'd0, 1'b0, "R4");
    window(16'h0000, 16'h0042, "R4");

    // R6 / R8: three actions on one tick
    load(16'h0100, 3'd2, 6'd0, 1'b0, 1'b0, 1'b1, "R1");
    load(16'h0100, 3'd3, 6'd0, 1'b1, 1'b0, 1'b1, "R1");
    load(16'h0100, 3'd4, 6'd2, 1'b0, 1'b0, 1'b1, "R1");
    load(16'h0100, 3'd6, 6'd0, 1'b0, 1'b0, 1'b1, "R1");
    push(6'b000100, 1'b1, 1'b1, 4'b0100, 1'b1, "R6");
    window(16'h0100, 16'h0000, "R8");

    // R7: set and clear of line 5 on one tick, set wins
    load(16'h0200, 3'd0, 6'b100000, 1'b0, 1'b0, 1'b1, "R1");
    load(16'h0200, 3'd1, 6'b100001, 1'b0, 1'b0, 1'b1, "R1");
    push(6'b100100, 1'b0, 1'b0, 4'd0, 1'b0, "R7");
    window(16'h0200, 16'h0000, "R7");

    // R2: fill all slots, refused ninth load never fires
    for (int i = 0; i < 8; i++) load(16'h7777, 3'd2, 6'd0, 1'b0, 1'b0, 1'b1, "R1");
    check(full == 1'b1, "R2", "full after 8 loads", int'(full), 1);
    load(16'h7777, 3'd4, 6'd3, 1'b1, 1'b0, 1'b0, "R2");
    push(6'b100100, 1'b1, 1'b0, 4'd0, 1'b0, "R2");
    window(16'h7777, 16'h0000, "R2");
    check(full == 1'b0, "R5", "full after firing", int'(full), 0);

    // R4: exact equality only
    load(16'h0500, 3'd4, 6'd1, 1'b0, 1'b0, 1'b1, "R1");
    window(16'h0501, 16'h0500, "R4");
    push(6'b100100, 1'b0, 1'b0, 4'b0010, 1'b0, "R4");
    window(16'h0500, 16'h0000, "R4");

    // R4: timer select 0 ignores timer2
    load(16'h0600, 3'd2, 6'd0, 1'b0, 1'b0, 1'b1, "R1");
    window(16'h0000, 16'h0600, "R4");
    push(6'b100100, 1'b1, 1'b0, 4'd0, 1'b0, "R4");
    window(16'h0600, 16'h0000, "R4");

    check(full == 1'b0, "R5", "store drained", int'(full), 0);
    summary();
    $finish;
  end
endmodule